// File: doc/BRIEF.md
# Byte-Lane Word FIFO

A 32-bit word queue whose storage is split into four independent 8-bit lane queues. A host whose data path is at most 16 bits wide fills a word in pieces: two 16-bit writes (low half and high half in either order), four byte writes, or one 32-bit write with every byte enable set. Each enabled byte pushes only its own lane. There may be idle cycles between the pieces of a word.

Each lane reports its own not-empty bit. The combined word-ready flag is the AND of the four lane bits, so a downstream consumer such as a launch state machine never sees a half-written word as ready. A single-bit status tied only to the least significant lane is kept for consumers that watch one lane. That bit is trustworthy only when that lane is written last.

The read side is a valid/ready stream. `rd_valid` is the word-ready flag, and a word is taken on a clock edge where `rd_valid` and `rd_ready` are both high. `rd_ready` may be held high at any time; while `rd_valid` is low it has no effect. The write side has no back-pressure. A byte aimed at a full lane is discarded and marks a sticky per-lane overflow flag. Reset is synchronous and active high.

Top module: `lane_split_fifo`

## Requirements
- R1: Lane i (i = 0..3) stores `wr_data[8i+7:8i]`. It is pushed only on a cycle where `wr_en` is high and `wr_be[i]` is high. `rd_data[8i+7:8i]` shows the oldest byte of lane i.
- R2: `lane_ne[i]` is high exactly when lane i holds at least one byte. It changes at the clock edge that accepts the write or pop, and bits of lanes that were not written or popped keep their value.
- R3: Writing the low half first (`wr_be`=0011) and the high half later (`wr_be`=1100), with or without idle cycles between, steps `lane_ne` from 0000 to 0011 to 1111. High half first steps it 0000 to 1100 to 1111. One write with `wr_be`=1111 reaches 1111 directly.
- R4: `rd_valid` is high only when all four bits of `lane_ne` are high.
- R5: On an edge with `rd_valid` and `rd_ready` both high, one byte leaves every lane. Words come out in the order they were completed.
- R6: `rd_ready` while `rd_valid` is low is ignored: no lane loses a byte.
- R7: Each lane holds 4 bytes. A byte written to a full lane is dropped and sets `lane_ovf[i]`, which stays set until reset. Other enabled lanes of the same write are still accepted.
- R8: A lane that is full at a clock edge drops a write on that edge even when a pop on the same edge removes a byte. A lane that is not full accepts a push and a pop on the same edge, and its count is unchanged.
- R9: `lane0_ne` equals `lane_ne[0]` at all times.
- R10: While `rst` is high at a clock edge, all lanes are emptied and `lane_ovf` is cleared. After that edge `lane_ne`=0000 and `rd_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| wr_be | input | 4 | Byte enables; bit i selects lane i |
| wr_data | input | 32 | Host write data, byte i for lane i |
| lane_ne | output | 4 | Per-lane not-empty status |
| lane_ovf | output | 4 | Sticky per-lane overflow flags |
| lane0_ne | output | 1 | Single-lane status, equal to lane 0 not-empty |
| rd_valid | output | 1 | Word ready: every lane holds a byte |
| rd_ready | input | 1 | Consumer accepts the presented word |
| rd_data | output | 32 | Oldest complete word |

## Verification
A host write and a word pop can happen on the same clock edge. The bench provokes this twice. In the first case every lane is full, so the write must be dropped (R8) even though the pop frees space. In the second case each lane holds one byte, so both actions must take effect and the lane counts are unchanged. Each case is judged at the ports. In the first case the bench reads the overflow flags and then drains the queue to confirm the dropped word never appears. In the second case it confirms that the new word is the one presented next and that the queue is empty after it.

// File: rtl/lane_fifo_pkg.sv
package lane_fifo_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned LANES_DEF  = 4;
  localparam int unsigned LANE_W_DEF = 8;
  localparam int unsigned DEPTH_DEF  = 4;

  // Pointer width for a queue of a given depth (at least one bit).
  function automatic int unsigned ptr_w(input int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

  // Counter width able to hold 0..depth.
  function automatic int unsigned cnt_w(input int unsigned depth);
    return $clog2(depth + 1);
  endfunction
endpackage

// File: rtl/lane_fifo.sv
module lane_fifo
  import lane_fifo_pkg::*;
#(
  parameter int unsigned W     = LANE_W_DEF,
  parameter int unsigned DEPTH = DEPTH_DEF
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         not_empty,
  output logic         ovf
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned PW = ptr_w(DEPTH);
  localparam int unsigned CW = cnt_w(DEPTH);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic          full, take_in, take_out;

  // Fullness is judged on the count before this edge; a pop on the same edge does not make room.
  assign full     = (cnt == CW'(DEPTH));
  assign take_in  = push && !full;
  assign take_out = pop && (cnt != '0);

  always_ff @(posedge clk) begin
    if (take_in) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
      ovf  <= 1'b0;
    end else begin
      if (take_in)  wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (take_out) rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
      unique case ({take_in, take_out})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
      if (push && full) ovf <= 1'b1;
    end
  end

  assign dout      = mem[rptr];
  assign not_empty = (cnt != '0);
endmodule

// File: rtl/wr_steer.sv
module wr_steer
  import lane_fifo_pkg::*;
#(
  parameter int unsigned LANES  = LANES_DEF,
  parameter int unsigned LANE_W = LANE_W_DEF
) (
  input  logic                          wr_en,
  input  logic [LANES-1:0]              wr_be,
  input  logic [LANES*LANE_W-1:0]       wr_data,
  output logic [LANES-1:0]              lane_push,
  output logic [LANES-1:0][LANE_W-1:0]  lane_din
);
  timeunit 1ns;
  timeprecision 1ps;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_push[i] = wr_en && wr_be[i];
    assign lane_din[i]  = wr_data[i*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/word_gate.sv
module word_gate #(
  parameter int unsigned LANES = 4
) (
  input  logic [LANES-1:0] lane_ne,
  input  logic             rd_ready,
  output logic             rd_valid,
  output logic             pop_all
);
  timeunit 1ns;
  timeprecision 1ps;

  // A word exists only when every lane holds a byte.
  assign rd_valid = &lane_ne;
  assign pop_all  = rd_valid && rd_ready;
endmodule

// File: rtl/lane_split_fifo.sv
module lane_split_fifo
  import lane_fifo_pkg::*;
#(
  parameter int unsigned LANES  = LANES_DEF,
  parameter int unsigned LANE_W = LANE_W_DEF,
  parameter int unsigned DEPTH  = DEPTH_DEF
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [LANES-1:0]        wr_be,
  input  logic [LANES*LANE_W-1:0] wr_data,
  output logic [LANES-1:0]        lane_ne,
  output logic [LANES-1:0]        lane_ovf,
  output logic                    lane0_ne,
  output logic                    rd_valid,
  input  logic                    rd_ready,
  output logic [LANES*LANE_W-1:0] rd_data
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [LANES-1:0]             lane_push;
  logic [LANES-1:0][LANE_W-1:0] lane_din;
  logic [LANES-1:0][LANE_W-1:0] lane_head;
  logic                         pop_all;

  wr_steer #(.LANES(LANES), .LANE_W(LANE_W)) u_steer (
    .wr_en     (wr_en),
    .wr_be     (wr_be),
    .wr_data   (wr_data),
    .lane_push (lane_push),
    .lane_din  (lane_din)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    lane_fifo #(.W(LANE_W), .DEPTH(DEPTH)) u_fifo (
      .clk       (clk),
      .rst       (rst),
      .push      (lane_push[i]),
      .din       (lane_din[i]),
      .pop       (pop_all),
      .dout      (lane_head[i]),
      .not_empty (lane_ne[i]),
      .ovf       (lane_ovf[i])
    );
    assign rd_data[i*LANE_W +: LANE_W] = lane_head[i];
  end

  word_gate #(.LANES(LANES)) u_gate (
    .lane_ne  (lane_ne),
    .rd_ready (rd_ready),
    .rd_valid (rd_valid),
    .pop_all  (pop_all)
  );

  // Single-lane status follows the least significant lane only.
  assign lane0_ne = lane_ne[0];
endmodule

// File: rtl/lane_split_fifo_chk.sv
module lane_split_fifo_chk #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    wr_en,
  input logic [LANES-1:0]        wr_be,
  input logic [LANES*LANE_W-1:0] wr_data,
  input logic [LANES-1:0]        lane_ne,
  input logic [LANES-1:0]        lane_ovf,
  input logic                    lane0_ne,
  input logic                    rd_valid,
  input logic                    rd_ready,
  input logic [LANES*LANE_W-1:0] rd_data
);
  timeunit 1ns;
  timeprecision 1ps;

  logic unused_data;
  assign unused_data = ^{wr_data, rd_data};

  a_r4_ready_full: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (&lane_ne));

  a_r9_lane0_follow: assert property (@(posedge clk) disable iff (rst)
    lane0_ne == lane_ne[0]);

  a_r6_pop_ignored: assert property (@(posedge clk) disable iff (rst)
    (rd_ready && !rd_valid && !wr_en) |=> $stable(lane_ne));

  a_r2_lane_isolated: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !rd_ready) |=> (((lane_ne ^ $past(lane_ne)) & ~$past(wr_be)) == '0));

  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (rst || $past(rst))
    (($past(lane_ovf) & ~lane_ovf) == '0));

  a_r10_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (lane_ne == '0 && lane_ovf == '0 && !rd_valid));
endmodule

bind lane_split_fifo lane_split_fifo_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (.*);

// File: tb/sim_lane_split_fifo.sv
module sim_lane_split_fifo;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_be = '0;
  logic [31:0] wr_data = '0;
  logic        rd_ready = 1'b0;
  logic [3:0]  lane_ne, lane_ovf;
  logic        lane0_ne, rd_valid;
  logic [31:0] rd_data;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk; // 8 ns period, 125 MHz

  lane_split_fifo u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
    .lane_ne(lane_ne), .lane_ovf(lane_ovf), .lane0_ne(lane0_ne),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_be = be; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_be = '0;
  endtask

  task automatic pop_word(input logic [31:0] exp, input string tag);
    @(negedge clk);
    chk({tag, " rd_valid"}, {31'b0, rd_valid}, 32'd1);
    chk({tag, " rd_data"}, rd_data, exp);
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
  endtask

  // R10: state after reset
  task automatic t_reset();
    do_reset();
    chk("R10 lane_ne", {28'b0, lane_ne}, 32'h0);
    chk("R10 lane_ovf", {28'b0, lane_ovf}, 32'h0);
    chk("R10 rd_valid", {31'b0, rd_valid}, 32'h0);
  endtask

  // R3/R4/R9/R1: low half first with idle gap
  task automatic t_low_first();
    wr(4'b0011, 32'h0000BBAA);
    chk("R3 low half", {28'b0, lane_ne}, 32'h3);
    chk("R4 partial not ready", {31'b0, rd_valid}, 32'h0);
    chk("R9 lane0 status", {31'b0, lane0_ne}, 32'h1);
    repeat (3) @(negedge clk);
    chk("R3 idle gap", {28'b0, lane_ne}, 32'h3);
    wr(4'b1100, 32'hDDCC0000);
    chk("R3 full word", {28'b0, lane_ne}, 32'hF);
    pop_word(32'hDDCCBBAA, "R1 assembled word");
    chk("R5 emptied", {28'b0, lane_ne}, 32'h0);
  endtask

  // R3/R9: high half first, lane0 status stays low until last
  task automatic t_high_first();
    wr(4'b1100, 32'h44330000);
    chk("R3 high half", {28'b0, lane_ne}, 32'hC);
    chk("R9 lane0 low", {31'b0, lane0_ne}, 32'h0);
    chk("R4 partial high", {31'b0, rd_valid}, 32'h0);
    wr(4'b0011, 32'h00002211);
    chk("R3 completed", {28'b0, lane_ne}, 32'hF);
    pop_word(32'h44332211, "R1 high first");
  endtask

  // R5: ordering across 32-bit and byte writes
  task automatic t_order();
    wr(4'b1111, 32'h11223344);
    chk("R3 single wide write", {28'b0, lane_ne}, 32'hF);
    wr(4'b1111, 32'h55667788);
    wr(4'b0001, 32'h000000A0);
    wr(4'b0100, 32'h00A20000);
    wr(4'b1000, 32'hA3000000);
    wr(4'b0010, 32'h0000A100);
    pop_word(32'h11223344, "R5 order 1");
    pop_word(32'h55667788, "R5 order 2");
    pop_word(32'hA3A2A1A0, "R5 order 3");
    chk("R5 drained", {31'b0, rd_valid}, 32'h0);
  endtask

  // R6: pop request with partial word
  task automatic t_ignore_pop();
    wr(4'b0001, 32'h00000077);
    @(negedge clk) rd_ready = 1'b1;
    repeat (2) @(negedge clk);
    rd_ready = 1'b0;
    chk("R6 pop ignored", {28'b0, lane_ne}, 32'h1);
    wr(4'b1110, 32'h99888800);
    pop_word(32'h99888877, "R6 byte kept");
  endtask

  // R7: overflow on lane 0
  task automatic t_overflow();
    for (int k = 1; k <= 5; k++) wr(4'b0001, 32'(k));
    chk("R7 ovf set", {28'b0, lane_ovf}, 32'h1);
    chk("R7 lane status", {28'b0, lane_ne}, 32'h1);
    wr(4'b1111, 32'hA3A2A1FF);
    chk("R7 other lanes accepted", {28'b0, lane_ne}, 32'hF);
    pop_word(32'hA3A2A101, "R7 dropped byte absent");
    chk("R7 after pop", {28'b0, lane_ne}, 32'h1);
    chk("R7 sticky", {28'b0, lane_ovf}, 32'h1);
    do_reset();
    chk("R10 ovf cleared", {28'b0, lane_ovf}, 32'h0);
  endtask

  task automatic wr_and_pop(input logic [31:0] d, input logic [31:0] exp_head, input string tag);
    @(negedge clk);
    chk({tag, " head"}, rd_data, exp_head);
    wr_en = 1'b1; wr_be = 4'b1111; wr_data = d; rd_ready = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wr_be = '0; rd_ready = 1'b0;
  endtask

  // R8: write and pop on the same edge
  task automatic t_same_cycle();
    wr(4'b1111, 32'hC0C0C001);
    wr(4'b1111, 32'hC0C0C002);
    wr(4'b1111, 32'hC0C0C003);
    wr(4'b1111, 32'hC0C0C004);
    wr_and_pop(32'hC0C0C005, 32'hC0C0C001, "R8 full");
    chk("R8 full write dropped", {28'b0, lane_ovf}, 32'hF);
    pop_word(32'hC0C0C002, "R8 drain 2");
    pop_word(32'hC0C0C003, "R8 drain 3");
    pop_word(32'hC0C0C004, "R8 drain 4");
    chk("R8 dropped word absent", {31'b0, rd_valid}, 32'h0);
    do_reset();
    wr(4'b1111, 32'hE0000006);
    wr_and_pop(32'hE0000007, 32'hE0000006, "R8 room");
    chk("R8 count kept", {28'b0, lane_ne}, 32'hF);
    chk("R8 no overflow", {28'b0, lane_ovf}, 32'h0);
    pop_word(32'hE0000007, "R8 new word");
    chk("R8 empty after", {31'b0, rd_valid}, 32'h0);
  endtask

  initial begin
    t_reset();
    t_low_first();
    t_high_first();
    t_order();
    t_ignore_pop();
    t_overflow();
    t_same_cycle();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all) actual=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule